// File: doc/BRIEF.md
# Shared Accelerator Allocation Manager

This block sits between a group of processor cores and a pool of shared accelerators. It hands the accelerators out through a four-message exchange. A core first asks which accelerators of a given type exist and how long it would wait for one. It then reserves that type and waits for a grant. Once it holds an accelerator, the core commands it with a function code and the address of a task descriptor. When the accelerator signals that it has finished, the owning core receives a notice and sends a free message to hand the accelerator back.

Each accelerator has a fixed type set by a parameter, a busy bit and an owner field. Reservations wait in one first-in first-out queue and are granted strictly from its head. The block accepts at most one core message per cycle.

Every answer to a core appears one cycle after the message that caused it. Each such answer is a reply to a query, a grant, a start pulse to an accelerator, a completion notice or an error pulse.

Top module: `accel_alloc_mgr`

## Requirements
- R1: While reset is asserted, and in the first cycles after it is released, every output is zero: no reply, no grant, no start, no notice, no error. All accelerators begin free.
- R2: Message kinds are 0 query, 1 reserve, 2 command and 3 free. At most one core is accepted per cycle, shown one-hot on `in_accept`. The accepted core is the lowest-indexed core whose message is eligible. A core keeps its message valid until it is accepted.
- R3: An accepted query for type T produces `rsp_valid` in the next cycle. The reply carries the core index and a mask of every accelerator whose type is T. The default types are accelerators 0 and 1 of type 0, accelerator 2 of type 1 and accelerator 3 of type 2. The reply also carries a wait estimate equal to the number of reservations of type T queued at acceptance times TASK_CYC, which defaults to 16.
- R4: Reservations are granted in arrival order, strictly from the queue head. The head is granted the lowest-indexed free accelerator of its type. A blocked head also holds back later entries, even when those entries could be served. A grant is reported on `gnt_valid`/`gnt_core`/`gnt_acc` one cycle after the head is found servable.
- R5: A reserve message is not eligible while the queue holds QDEPTH entries (4 by default). It is not accepted, and a higher-indexed core with another kind of message is accepted instead.
- R6: A granted accelerator becomes busy and owned by the granted core. It is not granted again until its owner frees it.
- R7: A command from the owning core pulses `acc_start` for that accelerator in the next cycle. The function code and descriptor address appear on `acc_func` and `acc_addr` in that same cycle.
- R8: A command naming an accelerator that the sender does not own, or that is not busy, starts nothing and pulses `err` in the next cycle.
- R9: A done pulse from a busy accelerator raises the owner's bit of `note_done` in the next cycle. A done pulse from a free accelerator raises no bit.
- R10: A free message from the owner releases the accelerator, and a waiting reservation of its type can then be granted.
- R11: A free message from a core that is not the owner, or for an accelerator that is not busy, changes no state and pulses `err` in the next cycle. The accelerator stays held, so it is not granted and its owner can still command it.
- R12: An accelerator released in a cycle is seen as free by the grant logic in the following cycle. Its grant is therefore reported two cycles after the free message is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | NCORE | Per-core message valid |
| in_kind | input | 2*NCORE | Per-core message kind |
| in_type | input | TW*NCORE | Per-core accelerator type (query, reserve) |
| in_acc | input | AW*NCORE | Per-core accelerator id (command, free) |
| in_func | input | FUNC_W*NCORE | Per-core function code (command) |
| in_addr | input | ADDR_W*NCORE | Per-core task-descriptor address (command) |
| in_accept | output | NCORE | One-hot accept of the message this cycle |
| rsp_valid | output | 1 | Query reply valid |
| rsp_core | output | CW | Core the reply is for |
| rsp_cand | output | NACC | Mask of accelerators of the queried type |
| rsp_wait | output | WAIT_W | Estimated wait in cycles |
| gnt_valid | output | 1 | Grant valid |
| gnt_core | output | CW | Core receiving the grant |
| gnt_acc | output | AW | Accelerator granted |
| acc_start | output | NACC | Per-accelerator start pulse |
| acc_func | output | FUNC_W | Function code for the started accelerator |
| acc_addr | output | ADDR_W | Descriptor address for the started accelerator |
| acc_done | input | NACC | Per-accelerator completion pulse |
| note_done | output | NCORE | Per-core completion notice |
| err | output | 1 | Ownership error pulse |

## Verification
The hardest state to reach is a full reservation queue with a blocked head, because a grant drains the queue whenever a matching accelerator is free. The stimulus gets there by reserving a type that no accelerator carries. Those entries can never leave, so the full-queue refusal and a wait estimate of four times the task constant both become visible. Head-of-line blocking is reached earlier by holding every type-0 accelerator and then queueing a type-1 reservation behind a type-0 one. A behavioural model with plain queues predicts every output on every cycle, including simultaneous messages from all cores.

// File: rtl/aam_pkg.sv
package aam_pkg;
  typedef enum logic [1:0] {
    MSG_QRY  = 2'd0,
    MSG_RSV  = 2'd1,
    MSG_CMD  = 2'd2,
    MSG_FREE = 2'd3
  } msg_kind_e;
endpackage

// File: rtl/aam_pick.sv
module aam_pick #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  onehot,
  output logic [IW-1:0] idx,
  output logic          any
);
  // lowest set bit wins
  always_comb begin
    onehot = '0;
    idx    = '0;
    any    = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        onehot    = '0;
        onehot[i] = 1'b1;
        idx       = IW'(i);
        any       = 1'b1;
      end
    end
  end
endmodule

// File: rtl/aam_rsvq.sv
module aam_rsvq #(
  parameter int DEPTH = 4,
  parameter int CW    = 2,
  parameter int TW    = 2,
  localparam int PW   = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [CW-1:0]   push_core,
  input  logic [TW-1:0]   push_type,
  input  logic            pop,
  output logic [CW-1:0]   head_core,
  output logic [TW-1:0]   head_type,
  output logic            empty,
  output logic            full,
  input  logic [TW-1:0]   qry_type,
  output logic [CNTW-1:0] qry_cnt
);
  logic [CW-1:0]   core_q [DEPTH];
  logic [TW-1:0]   type_q [DEPTH];
  logic [PW-1:0]   rd_q, rd_d, wr_q, wr_d;
  logic [CNTW-1:0] cnt_q, cnt_d;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == CNTW'(DEPTH));
  assign head_core = core_q[rd_q];
  assign head_type = type_q[rd_q];

  always_comb begin
    rd_d  = pop  ? wrap_inc(rd_q) : rd_q;
    wr_d  = push ? wrap_inc(wr_q) : wr_q;
    cnt_d = cnt_q + CNTW'(push) - CNTW'(pop);
  end

  // entries of the queried type that are waiting
  always_comb begin
    logic [PW-1:0] j;
    qry_cnt = '0;
    for (int k = 0; k < DEPTH; k++) begin
      j = PW'((int'(rd_q) + k) % DEPTH);
      if ((k < int'(cnt_q)) && (type_q[j] == qry_type))
        qry_cnt = qry_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      core_q[wr_q] <= push_core;
      type_q[wr_q] <= push_type;
    end
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);
endmodule

// File: rtl/aam_pool.sv
module aam_pool #(
  parameter int NACC = 4,
  parameter int CW   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NACC-1:0]           set_vec,
  input  logic [CW-1:0]             set_core,
  input  logic [NACC-1:0]           clr_vec,
  output logic [NACC-1:0]           busy,
  output logic [NACC-1:0][CW-1:0]   owner
);
  logic [NACC-1:0]         busy_d;
  logic [NACC-1:0][CW-1:0] owner_d;

  always_comb begin
    busy_d  = busy;
    owner_d = owner;
    for (int i = 0; i < NACC; i++) begin
      if (clr_vec[i]) busy_d[i] = 1'b0;
      if (set_vec[i]) begin
        busy_d[i]  = 1'b1;
        owner_d[i] = set_core;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= '0;
      owner <= '0;
    end else begin
      busy  <= busy_d;
      owner <= owner_d;
    end
  end

  // R12
  set_clr_split_chk: assert property (@(posedge clk) disable iff (!rst_n) (set_vec & clr_vec) == '0);
  // R6
  regrant_chk: assert property (@(posedge clk) disable iff (!rst_n) (set_vec & busy) == '0);
endmodule

// File: rtl/accel_alloc_mgr.sv
module accel_alloc_mgr import aam_pkg::*; #(
  parameter int NCORE    = 4,
  parameter int NACC     = 4,
  parameter int NTYPE    = 4,
  parameter int QDEPTH   = 4,
  parameter int FUNC_W   = 4,
  parameter int ADDR_W   = 16,
  parameter int TASK_CYC = 16,
  parameter int WAIT_W   = 8,
  parameter logic [NACC*$clog2(NTYPE)-1:0] TYPE_MAP = 8'b10_01_00_00,
  localparam int CW   = $clog2(NCORE),
  localparam int AW   = $clog2(NACC),
  localparam int TW   = $clog2(NTYPE),
  localparam int CNTW = $clog2(QDEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NCORE-1:0]         in_valid,
  input  logic [2*NCORE-1:0]       in_kind,
  input  logic [TW*NCORE-1:0]      in_type,
  input  logic [AW*NCORE-1:0]      in_acc,
  input  logic [FUNC_W*NCORE-1:0]  in_func,
  input  logic [ADDR_W*NCORE-1:0]  in_addr,
  output logic [NCORE-1:0]         in_accept,
  output logic                     rsp_valid,
  output logic [CW-1:0]            rsp_core,
  output logic [NACC-1:0]          rsp_cand,
  output logic [WAIT_W-1:0]        rsp_wait,
  output logic                     gnt_valid,
  output logic [CW-1:0]            gnt_core,
  output logic [AW-1:0]            gnt_acc,
  output logic [NACC-1:0]          acc_start,
  output logic [FUNC_W-1:0]        acc_func,
  output logic [ADDR_W-1:0]        acc_addr,
  input  logic [NACC-1:0]          acc_done,
  output logic [NCORE-1:0]         note_done,
  output logic                     err
);
  // reset: asserted at once, released after two clocks
  logic [1:0] rsync_q;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q = rsync_q[1];

  logic [NCORE-1:0][1:0]        kind_c;
  logic [NCORE-1:0][TW-1:0]     type_c;
  logic [NCORE-1:0][AW-1:0]     acc_c;
  logic [NCORE-1:0][FUNC_W-1:0] func_c;
  logic [NCORE-1:0][ADDR_W-1:0] addr_c;
  logic [NCORE-1:0]             elig;
  logic                         q_full, q_empty;

  generate
    for (genvar c = 0; c < NCORE; c++) begin : g_core
      assign kind_c[c] = in_kind[c*2 +: 2];
      assign type_c[c] = in_type[c*TW +: TW];
      assign acc_c[c]  = in_acc[c*AW +: AW];
      assign func_c[c] = in_func[c*FUNC_W +: FUNC_W];
      assign addr_c[c] = in_addr[c*ADDR_W +: ADDR_W];
      assign elig[c]   = in_valid[c] && !((kind_c[c] == MSG_RSV) && q_full);
    end
  endgenerate

  logic [CW-1:0] sel_c;
  logic          sel_any;
  aam_pick #(.N(NCORE)) u_core_pick (
    .req(elig), .onehot(in_accept), .idx(sel_c), .any(sel_any)
  );

  msg_kind_e         sel_kind;
  logic [TW-1:0]     sel_type;
  logic [AW-1:0]     sel_acc;
  logic [FUNC_W-1:0] sel_func;
  logic [ADDR_W-1:0] sel_addr;
  assign sel_kind = msg_kind_e'(kind_c[sel_c]);
  assign sel_type = type_c[sel_c];
  assign sel_acc  = acc_c[sel_c];
  assign sel_func = func_c[sel_c];
  assign sel_addr = addr_c[sel_c];

  logic [NACC-1:0]         busy;
  logic [NACC-1:0][CW-1:0] owner;
  logic [CW-1:0]           head_core;
  logic [TW-1:0]           head_type;
  logic [CNTW-1:0]         qry_cnt;

  logic [NACC-1:0] free_match, cand, fr_onehot, clr_vec;
  logic [AW-1:0]   fr_idx;
  logic            grant_en;

  generate
    for (genvar i = 0; i < NACC; i++) begin : g_acc
      assign free_match[i] = !q_empty && !busy[i] && (TYPE_MAP[i*TW +: TW] == head_type);
      assign cand[i]       = (TYPE_MAP[i*TW +: TW] == sel_type);
    end
  endgenerate

  aam_pick #(.N(NACC)) u_acc_pick (
    .req(free_match), .onehot(fr_onehot), .idx(fr_idx), .any(grant_en)
  );

  logic own_ok, req_hit, push_rsv, cmd_ok, free_ok, bad_own;
  assign own_ok   = busy[sel_acc] && (owner[sel_acc] == sel_c);
  assign req_hit  = sel_any && (sel_kind == MSG_QRY);
  assign push_rsv = sel_any && (sel_kind == MSG_RSV);
  assign cmd_ok   = sel_any && (sel_kind == MSG_CMD) && own_ok;
  assign free_ok  = sel_any && (sel_kind == MSG_FREE) && own_ok;
  assign bad_own  = sel_any && ((sel_kind == MSG_CMD) || (sel_kind == MSG_FREE)) && !own_ok;
  assign clr_vec  = free_ok ? (NACC'(1) << sel_acc) : '0;

  aam_rsvq #(.DEPTH(QDEPTH), .CW(CW), .TW(TW)) u_rsvq (
    .clk(clk), .rst_n(rst_q),
    .push(push_rsv), .push_core(sel_c), .push_type(sel_type),
    .pop(grant_en), .head_core(head_core), .head_type(head_type),
    .empty(q_empty), .full(q_full),
    .qry_type(sel_type), .qry_cnt(qry_cnt)
  );

  aam_pool #(.NACC(NACC), .CW(CW)) u_pool (
    .clk(clk), .rst_n(rst_q),
    .set_vec(fr_onehot), .set_core(head_core), .clr_vec(clr_vec),
    .busy(busy), .owner(owner)
  );

  // next-state of the registered outputs
  logic [WAIT_W-1:0] wait_d;
  logic [NACC-1:0]   start_d;
  logic [NCORE-1:0]  note_d;
  always_comb begin
    wait_d  = WAIT_W'(int'(qry_cnt) * TASK_CYC);
    start_d = cmd_ok ? (NACC'(1) << sel_acc) : '0;
    note_d  = '0;
    for (int i = 0; i < NACC; i++)
      if (acc_done[i] && busy[i]) note_d[owner[i]] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      rsp_valid <= 1'b0;
      rsp_core  <= '0;
      rsp_cand  <= '0;
      rsp_wait  <= '0;
      gnt_valid <= 1'b0;
      gnt_core  <= '0;
      gnt_acc   <= '0;
      acc_start <= '0;
      acc_func  <= '0;
      acc_addr  <= '0;
      note_done <= '0;
      err       <= 1'b0;
    end else begin
      rsp_valid <= req_hit;
      if (req_hit) begin
        rsp_core <= sel_c;
        rsp_cand <= cand;
        rsp_wait <= wait_d;
      end
      gnt_valid <= grant_en;
      if (grant_en) begin
        gnt_core <= head_core;
        gnt_acc  <= fr_idx;
      end
      acc_start <= start_d;
      if (cmd_ok) begin
        acc_func <= sel_func;
        acc_addr <= sel_addr;
      end
      note_done <= note_d;
      err       <= bad_own;
    end
  end

  // R2
  accept_onehot_chk: assert property (@(posedge clk) disable iff (!rst_q) $onehot0(in_accept));
  // R3
  rsp_cause_chk: assert property (@(posedge clk) disable iff (!rst_q)
    rsp_valid |-> $past(sel_any && (sel_kind == MSG_QRY)));
  // R7
  start_owned_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (acc_start != '0) |-> ($onehot(acc_start) && ((acc_start & busy) == acc_start)));
  // R11
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_q)
    err |-> $past(sel_any && ((sel_kind == MSG_CMD) || (sel_kind == MSG_FREE))));
  // R9
  note_cause_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (note_done != '0) |-> $past(acc_done != '0));
endmodule

// File: tb/sim_accel_alloc_mgr.sv
module sim_accel_alloc_mgr;
  localparam int CLK_P = 10;
  localparam int NC = 4, NA = 4, QD = 4, TC = 16;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic          rst_n;
  logic [NC-1:0] in_valid;
  logic [7:0]    in_kind, in_type, in_acc;
  logic [15:0]   in_func;
  logic [63:0]   in_addr;
  logic [NC-1:0] in_accept, note_done;
  logic          rsp_valid, gnt_valid, err;
  logic [1:0]    rsp_core, gnt_core, gnt_acc;
  logic [NA-1:0] rsp_cand, acc_start, acc_done;
  logic [7:0]    rsp_wait;
  logic [3:0]    acc_func;
  logic [15:0]   acc_addr;

  accel_alloc_mgr u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind), .in_type(in_type),
    .in_acc(in_acc), .in_func(in_func), .in_addr(in_addr), .in_accept(in_accept),
    .rsp_valid(rsp_valid), .rsp_core(rsp_core), .rsp_cand(rsp_cand), .rsp_wait(rsp_wait),
    .gnt_valid(gnt_valid), .gnt_core(gnt_core), .gnt_acc(gnt_acc),
    .acc_start(acc_start), .acc_func(acc_func), .acc_addr(acc_addr),
    .acc_done(acc_done), .note_done(note_done), .err(err)
  );

  int vectors = 0, miscompares = 0;
  bit finished = 1'b0;

  // reference model state
  int m_busy [NA];
  int m_own  [NA];
  int mq_c [QD];
  int mq_t [QD];
  int mq_n;
  int e_rsp_v, e_rsp_c, e_rsp_cand, e_rsp_w, e_g_v, e_g_c, e_g_a;
  int e_start, e_func, e_addr, e_note, e_err;

  function automatic int tmap(int i);
    return (i < 2) ? 0 : (i == 2) ? 1 : 2;
  endfunction

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NA; i++) begin m_busy[i] = 0; m_own[i] = 0; end
    mq_n = 0;
    e_rsp_v = 0; e_g_v = 0; e_start = 0; e_note = 0; e_err = 0;
  endtask

  // compare and advance, mid low phase
  initial begin
    model_reset();
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      begin
        int sel, ga, k, t, a, cnt, exp_acc, n_note, do_free, do_push;
        sel = -1;
        for (int c = 0; c < NC; c++) begin
          k = int'(in_kind[c*2 +: 2]);
          if (sel < 0 && in_valid[c] && !(k == 1 && mq_n == QD)) sel = c;
        end
        exp_acc = (sel >= 0) ? (1 << sel) : 0;
        chk("R2/R5 accept", int'(in_accept), exp_acc);
        chk("R3 rsp_valid", int'(rsp_valid), e_rsp_v);
        if (e_rsp_v != 0) begin
          chk("R3 rsp_core", int'(rsp_core), e_rsp_c);
          chk("R3 rsp_cand", int'(rsp_cand), e_rsp_cand);
          chk("R3 rsp_wait", int'(rsp_wait), e_rsp_w);
        end
        chk("R4/R6/R10/R12 gnt_valid", int'(gnt_valid), e_g_v);
        if (e_g_v != 0) begin
          chk("R4 gnt_core", int'(gnt_core), e_g_c);
          chk("R4/R6 gnt_acc", int'(gnt_acc), e_g_a);
        end
        chk("R7/R8 acc_start", int'(acc_start), e_start);
        if (e_start != 0) begin
          chk("R7 acc_func", int'(acc_func), e_func);
          chk("R7 acc_addr", int'(acc_addr), e_addr);
        end
        chk("R9 note_done", int'(note_done), e_note);
        chk("R8/R11 err", int'(err), e_err);

        if (!rst_n) model_reset();
        else begin
          ga = -1;
          if (mq_n > 0)
            for (int i = 0; i < NA; i++)
              if (ga < 0 && m_busy[i] == 0 && tmap(i) == mq_t[0]) ga = i;
          n_note = 0;
          for (int i = 0; i < NA; i++)
            if (acc_done[i] && m_busy[i] != 0) n_note |= (1 << m_own[i]);
          e_rsp_v = 0; e_start = 0; e_err = 0; do_free = -1; do_push = 0;
          t = 0;
          if (sel >= 0) begin
            k = int'(in_kind[sel*2 +: 2]);
            t = int'(in_type[sel*2 +: 2]);
            a = int'(in_acc[sel*2 +: 2]);
            if (k == 0) begin
              cnt = 0;
              for (int q = 0; q < mq_n; q++) if (mq_t[q] == t) cnt++;
              e_rsp_v = 1; e_rsp_c = sel; e_rsp_w = cnt * TC; e_rsp_cand = 0;
              for (int i = 0; i < NA; i++) if (tmap(i) == t) e_rsp_cand |= (1 << i);
            end else if (k == 1) do_push = 1;
            else if (m_busy[a] != 0 && m_own[a] == sel) begin
              if (k == 2) begin
                e_start = 1 << a;
                e_func = int'(in_func[sel*4 +: 4]);
                e_addr = int'(in_addr[sel*16 +: 16]);
              end else do_free = a;
            end else e_err = 1;
          end
          e_note = n_note;
          e_g_v = (ga >= 0) ? 1 : 0;
          if (ga >= 0) begin
            e_g_c = mq_c[0]; e_g_a = ga;
            m_busy[ga] = 1; m_own[ga] = mq_c[0];
            for (int q = 0; q < QD - 1; q++) begin mq_c[q] = mq_c[q+1]; mq_t[q] = mq_t[q+1]; end
            mq_n--;
          end
          if (do_free >= 0) m_busy[do_free] = 0;
          if (do_push != 0) begin mq_c[mq_n] = sel; mq_t[mq_n] = t; mq_n++; end
        end
      end
    end
  end

  task automatic put(int c, int k, int t, int a, int f, int ad);
    in_valid[c] = 1'b1;
    in_kind[c*2 +: 2]  = 2'(k);
    in_type[c*2 +: 2]  = 2'(t);
    in_acc[c*2 +: 2]   = 2'(a);
    in_func[c*4 +: 4]  = 4'(f);
    in_addr[c*16 +: 16] = 16'(ad);
  endtask

  task automatic send(int c, int k, int t, int a, int f, int ad);
    put(c, k, t, a, f, ad);
    #(CLK_P/4);
    while (!in_accept[c]) begin @(negedge clk); #(CLK_P/4); end
    @(negedge clk);
    in_valid[c] = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_done(int mask);
    acc_done = 4'(mask);
    @(negedge clk);
    acc_done = '0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual running expected done");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = '0; in_kind = '0; in_type = '0; in_acc = '0;
    in_func = '0; in_addr = '0; acc_done = '0;
    idle(3);
    #(CLK_P/4);
    // R1 reset state
    chk("R1 outputs idle", int'({rsp_valid, gnt_valid, acc_start, note_done, err}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    chk("R1 outputs idle after release", int'({rsp_valid, gnt_valid, acc_start, note_done, err}), 0);

    send(1, 0, 0, 0, 0, 0); idle(2);                       // R3 query, empty queue
    send(0, 1, 0, 0, 0, 0); send(1, 1, 0, 0, 0, 0);         // R4 two grants
    send(2, 1, 0, 0, 0, 0); idle(3);                       // R6 third waits
    send(3, 0, 0, 0, 0, 0); idle(1);                       // R3 wait one entry
    send(3, 1, 0, 0, 0, 0); send(3, 1, 1, 0, 0, 0); idle(3); // R4 head blocks type 1
    send(1, 0, 1, 0, 0, 0); idle(1);
    send(0, 2, 0, 0, 5, 16'h1234); idle(1);                // R7
    send(1, 2, 0, 0, 3, 16'h0042); idle(1);                // R8 non-owner command
    pulse_done(1); idle(1);                                // R9
    pulse_done(8); idle(1);                                // R9 free accelerator, no notice
    send(2, 3, 0, 0, 0, 0); idle(3);                       // R11 non-owner free
    send(1, 3, 0, 2, 0, 0); idle(2);                       // R11 free of idle accelerator
    send(0, 2, 0, 0, 9, 16'h00ff); idle(1);                // R11 owner still holds it
    send(0, 3, 0, 0, 0, 0); idle(3);                       // R10/R12 release then grant
    send(1, 3, 0, 1, 0, 0); idle(4);                       // R10 chain of grants
    fork                                                   // R2 contention
      send(0, 0, 2, 0, 0, 0);
      send(1, 0, 1, 0, 0, 0);
      send(2, 2, 0, 0, 7, 16'hbeef);
      send(3, 3, 0, 1, 0, 0);
    join
    idle(2);
    pulse_done(3); idle(2);                                // R9 two at once
    fork                                                   // R5 fill with unservable type
      send(0, 1, 3, 0, 0, 0);
      send(1, 1, 3, 0, 0, 0);
      send(2, 1, 3, 0, 0, 0);
      send(3, 1, 3, 0, 0, 0);
    join
    idle(1);
    send(1, 0, 3, 0, 0, 0); idle(1);                       // R3 wait of four entries
    put(0, 1, 0, 0, 0, 0);                                 // R5 held reserve
    send(2, 0, 0, 0, 0, 0);
    idle(3);
    in_valid[0] = 1'b0;
    idle(3);
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule